// File: doc/BRIEF.md
# Peripheral Pin Multiplexer with Programmable Priority

This block decides, pin by pin, who drives each digital I/O pad: the general-purpose output and direction registers, or one of several on-chip peripherals. Every peripheral owns a window of four consecutive pins. A per-peripheral location bit places that window at one of two alternative places. When windows overlap, a programmable rank picks the owner of each shared pin. A pin's select bit hands the pin over to its owning peripheral. The same select bit also removes the pin's pull resistor control.

The default build has three peripherals. Indices 0 and 1 are serial ports, and each runs in one of four modes. Index 2 is a four-channel timer. A serial port does not take every pin of its window in every mode: a flow-control-free UART leaves its two handshake pins free, and an SPI master leaves its select pin free. Those free pins can go to a lower-ranked peripheral. Pad input values always flow back to the peripherals at their current location, whatever the select and pull settings are. The whole block is combinational.

Top module: `pinmux_top`

## Requirements
- R1: A pin whose select bit is 0 drives `gpioOut` on `padOut` and `gpioDir` on `padOe`.
- R2: A pin whose select bit is 1 and which has an owner drives the owner's slot output and slot enable. Slot s of peripheral p is at bit p*4+s of `periOut` and `periOe`.
- R3: A pin whose select bit is 1 and which no peripheral claims has `padOe` = 0 and `padOut` = 0.
- R4: `padPullEn` equals `pullCfg` on pins whose select bit is 0. It is 0 on pins whose select bit is 1.
- R5: Peripheral p covers pins base..base+3. The base is 2*p when `locSel[p]` = 0, and NUM_PINS/2 + 2*p when `locSel[p]` = 1. Slot s sits on pin base+s.
- R6: Among the peripherals that claim a pin, the one with the smallest rank wins. Peripheral p's rank is `prioRank[2p+1:2p]`. On equal ranks the lower peripheral index wins.
- R7: A peripheral holds the pins it claims even when all its slot enables are 0. A lower-ranked peripheral then cannot drive those pins.
- R8: Serial port p uses the mode field `serMode[2p+1:2p]`. Mode 0 (UART, no flow control) claims slots 0 and 1 only. Mode 1 (UART with flow control) claims all four slots. Mode 2 (SPI master) claims slots 0 to 2. Mode 3 (SPI slave) claims all four slots. The timer always claims all four slots.
- R9: `periIn[p*4+s]` equals `padIn` at pin base+s for the peripheral's current location, whatever the values of `selBits` and `pullCfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| selBits | input | NUM_PINS | Per-pin peripheral select |
| pullCfg | input | NUM_PINS | Per-pin pull resistor request |
| gpioOut | input | NUM_PINS | GPIO output data |
| gpioDir | input | NUM_PINS | GPIO direction, 1 = output |
| padIn | input | NUM_PINS | Pad input values |
| locSel | input | NUM_PERIPH | Per-peripheral location choice |
| prioRank | input | NUM_PERIPH*RANK_W | Per-peripheral rank, lower wins |
| serMode | input | NUM_SERIAL*2 | Serial port mode fields |
| periOut | input | NUM_PERIPH*4 | Peripheral slot output values |
| periOe | input | NUM_PERIPH*4 | Peripheral slot output enables |
| padOut | output | NUM_PINS | Pad output value |
| padOe | output | NUM_PINS | Pad output enable |
| padPullEn | output | NUM_PINS | Pad pull resistor enable |
| periIn | output | NUM_PERIPH*4 | Pad values routed to peripheral slots |

## Verification
Two functions act on one pin in the same evaluation: serial-mode claim filtering and rank arbitration. A pin that a serial port releases in one mode must fall to the next-ranked peripheral in that same settle, and not stay with the serial port. The bench sweeps every combination of location bits, ranks and serial modes, so released pins land inside overlapping windows. It compares every pad with an owner computed from the window formula and the rank order. Directed cases with literal output-enable patterns cover the SPI-master and flow-control-free releases and an idle owner that blocks a lower-ranked peripheral.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int SLOTS   = 4;
  localparam int OWNER_W = 4;
  localparam int SLOT_W  = 2;

  typedef enum logic [1:0] {
    SER_UART_PLAIN = 2'd0,
    SER_UART_FLOW  = 2'd1,
    SER_SPI_MASTER = 2'd2,
    SER_SPI_SLAVE  = 2'd3
  } serModeT;

  // Strobe bundle from the owner resolver to the routing datapath
  typedef struct packed {
    logic               valid;
    logic [OWNER_W-1:0] owner;
    logic [SLOT_W-1:0]  slot;
  } routeT;

  function automatic int winBase(input int p, input logic loc, input int half);
    return (loc ? half : 0) + 2 * p;
  endfunction

  function automatic logic slotClaimed(input logic isSerial, input logic [1:0] mode,
                                       input int slot);
    if (!isSerial) return 1'b1;
    case (serModeT'(mode))
      SER_UART_PLAIN: return slot < 2;
      SER_SPI_MASTER: return slot < 3;
      default:        return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pinmux_owner.sv
module pinmux_owner
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_PERIPH = 3,
  parameter int NUM_SERIAL = 2,
  parameter int RANK_W     = 2
) (
  input  logic [NUM_PERIPH-1:0]        locSel,
  input  logic [NUM_PERIPH*RANK_W-1:0] prioRank,
  input  logic [NUM_SERIAL*2-1:0]      serMode,
  output routeT                        route [NUM_PINS]
);
  localparam int HALF = NUM_PINS / 2;

  logic [1:0] modeOf [NUM_PERIPH];

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_mode
    if (p < NUM_SERIAL) begin : g_ser
      assign modeOf[p] = serMode[p*2 +: 2];
    end else begin : g_tmr
      assign modeOf[p] = 2'd3;
    end
  end

  always_comb begin
    for (int pin = 0; pin < NUM_PINS; pin++) begin
      logic [RANK_W-1:0] bestRank;
      bestRank   = '1;
      route[pin] = '0;
      for (int p = 0; p < NUM_PERIPH; p++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (pin == winBase(p, locSel[p], HALF) + s &&
              slotClaimed(p < NUM_SERIAL, modeOf[p], s) &&
              (!route[pin].valid || prioRank[p*RANK_W +: RANK_W] < bestRank)) begin
            route[pin].valid = 1'b1;
            route[pin].owner = OWNER_W'(p);
            route[pin].slot  = SLOT_W'(s);
            bestRank         = prioRank[p*RANK_W +: RANK_W];
          end
        end
      end
    end
  end

endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_PERIPH = 3
) (
  input  routeT                       route [NUM_PINS],
  input  logic [NUM_PINS-1:0]         selBits,
  input  logic [NUM_PINS-1:0]         pullCfg,
  input  logic [NUM_PINS-1:0]         gpioOut,
  input  logic [NUM_PINS-1:0]         gpioDir,
  input  logic [NUM_PINS-1:0]         padIn,
  input  logic [NUM_PERIPH-1:0]       locSel,
  input  logic [NUM_PERIPH*SLOTS-1:0] periOut,
  input  logic [NUM_PERIPH*SLOTS-1:0] periOe,
  output logic [NUM_PINS-1:0]         padOut,
  output logic [NUM_PINS-1:0]         padOe,
  output logic [NUM_PINS-1:0]         padPullEn,
  output logic [NUM_PERIPH*SLOTS-1:0] periIn
);
  localparam int HALF = NUM_PINS / 2;

  always_comb begin
    for (int pin = 0; pin < NUM_PINS; pin++) begin
      int idx;
      idx = int'(route[pin].owner) * SLOTS + int'(route[pin].slot);
      if (!selBits[pin]) begin
        padOut[pin] = gpioOut[pin];
        padOe[pin]  = gpioDir[pin];
      end else if (route[pin].valid) begin
        padOut[pin] = periOut[idx];
        padOe[pin]  = periOe[idx];
      end else begin
        padOut[pin] = 1'b0;
        padOe[pin]  = 1'b0;
      end
    end
  end

  assign padPullEn = pullCfg & ~selBits;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_in
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign periIn[p*SLOTS+s] = padIn[winBase(p, locSel[p], HALF) + s];
    end
  end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_PERIPH = 3,
  parameter int NUM_SERIAL = 2,
  parameter int RANK_W     = 2
) (
  input  logic [NUM_PINS-1:0]          selBits,
  input  logic [NUM_PINS-1:0]          pullCfg,
  input  logic [NUM_PINS-1:0]          gpioOut,
  input  logic [NUM_PINS-1:0]          gpioDir,
  input  logic [NUM_PINS-1:0]          padIn,
  input  logic [NUM_PERIPH-1:0]        locSel,
  input  logic [NUM_PERIPH*RANK_W-1:0] prioRank,
  input  logic [NUM_SERIAL*2-1:0]      serMode,
  input  logic [NUM_PERIPH*4-1:0]      periOut,
  input  logic [NUM_PERIPH*4-1:0]      periOe,
  output logic [NUM_PINS-1:0]          padOut,
  output logic [NUM_PINS-1:0]          padOe,
  output logic [NUM_PINS-1:0]          padPullEn,
  output logic [NUM_PERIPH*4-1:0]      periIn
);
  routeT route [NUM_PINS];

  pinmux_owner #(
    .NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH),
    .NUM_SERIAL(NUM_SERIAL), .RANK_W(RANK_W)
  ) u_owner (
    .locSel(locSel), .prioRank(prioRank), .serMode(serMode), .route(route)
  );

  pinmux_route #(
    .NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH)
  ) u_route (
    .route(route), .selBits(selBits), .pullCfg(pullCfg),
    .gpioOut(gpioOut), .gpioDir(gpioDir), .padIn(padIn), .locSel(locSel),
    .periOut(periOut), .periOe(periOe),
    .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn), .periIn(periIn)
  );

endmodule

// File: rtl/pinmux_checks.sv
module pinmux_checks
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_PERIPH = 3
) (
  input routeT                      route [NUM_PINS],
  input logic [NUM_PINS-1:0]        selBits,
  input logic [NUM_PINS-1:0]        pullCfg,
  input logic [NUM_PINS-1:0]        gpioOut,
  input logic [NUM_PINS-1:0]        gpioDir,
  input logic [NUM_PINS-1:0]        padIn,
  input logic [NUM_PERIPH-1:0]      locSel,
  input logic [NUM_PERIPH*4-1:0]    periOut,
  input logic [NUM_PERIPH*4-1:0]    periOe,
  input logic [NUM_PINS-1:0]        padOut,
  input logic [NUM_PINS-1:0]        padOe,
  input logic [NUM_PINS-1:0]        padPullEn,
  input logic [NUM_PERIPH*4-1:0]    periIn
);
  localparam int HALF = NUM_PINS / 2;

  always_comb begin
    for (int pin = 0; pin < NUM_PINS; pin++) begin
      int idx;
      idx = int'(route[pin].owner) * SLOTS + int'(route[pin].slot);
      if (!selBits[pin]) begin
        p_gpio_path_r1: assert (padOut[pin] == gpioOut[pin] && padOe[pin] == gpioDir[pin]);
        p_pull_follows_r4: assert (padPullEn[pin] == pullCfg[pin]);
      end else begin
        p_pull_gated_r4: assert (!padPullEn[pin]);
        if (route[pin].valid) begin
          p_owner_drives_r2: assert (padOe[pin] == periOe[idx] && padOut[pin] == periOut[idx]);
        end else begin
          p_unclaimed_float_r3: assert (!padOe[pin] && !padOut[pin]);
        end
      end
      if (route[pin].valid) begin
        p_owner_window_r5: assert (pin == winBase(int'(route[pin].owner),
                                   locSel[route[pin].owner], HALF) + int'(route[pin].slot));
      end
    end
    for (int p = 0; p < NUM_PERIPH; p++) begin
      for (int s = 0; s < SLOTS; s++) begin
        p_input_loop_r9: assert (periIn[p*SLOTS+s] == padIn[winBase(p, locSel[p], HALF) + s]);
      end
    end
  end

endmodule

bind pinmux_top pinmux_checks #(
  .NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH)
) u_checks (
  .route(route), .selBits(selBits), .pullCfg(pullCfg), .gpioOut(gpioOut),
  .gpioDir(gpioDir), .padIn(padIn), .locSel(locSel), .periOut(periOut),
  .periOe(periOe), .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn),
  .periIn(periIn)
);

// File: tb/test_pinmux_top.sv
module test_pinmux_top;
  localparam int NP = 16, NPER = 3, NSER = 2, RW = 2, HALF = NP / 2;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0] selBits, pullCfg, gpioOut, gpioDir, padIn;
  logic [NPER-1:0] locSel;
  logic [NPER*RW-1:0] prioRank;
  logic [NSER*2-1:0] serMode;
  logic [NPER*4-1:0] periOut, periOe;
  logic [NP-1:0] padOut, padOe, padPullEn;
  logic [NPER*4-1:0] periIn;

  int nChecks = 0, nFails = 0;
  logic [31:0] rng = 32'h1234_5678;
  bit done = 0;

  pinmux_top i_pinmux_top (.*);

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // Owner per pin from the window formula, claim table and rank rule (R5, R6, R8)
  task automatic findOwner(input int pin, output bit found, output int idx);
    int bestRank;
    found = 0; idx = 0; bestRank = 99;
    for (int p = 0; p < NPER; p++) begin
      int base = (locSel[p] ? HALF : 0) + 2 * p;
      int mode = (p < NSER) ? int'(serMode[p*2 +: 2]) : 3;
      int lim  = (p >= NSER) ? 4 : (mode == 0 ? 2 : (mode == 2 ? 3 : 4));
      int r    = int'(prioRank[p*RW +: RW]);
      if (pin >= base && pin < base + lim && r < bestRank) begin
        found = 1; idx = p * 4 + (pin - base); bestRank = r;
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [NPER*4-1:0] expIn;
    for (int pin = 0; pin < NP; pin++) begin
      bit found; int idx; logic eo, eoe; string req;
      findOwner(pin, found, idx);
      if (!selBits[pin]) begin eo = gpioOut[pin]; eoe = gpioDir[pin]; req = "R1"; end
      else if (found) begin eo = periOut[idx]; eoe = periOe[idx]; req = "R2/R6/R8"; end
      else begin eo = 0; eoe = 0; req = "R3"; end
      check(req, {padOut[pin], padOe[pin], padPullEn[pin]},
            {eo, eoe, pullCfg[pin] & ~selBits[pin]});
    end
    for (int p = 0; p < NPER; p++)
      for (int s = 0; s < 4; s++)
        expIn[p*4+s] = padIn[(locSel[p] ? HALF : 0) + 2 * p + s];
    check("R9", 32'(periIn), 32'(expIn));
  endtask

  task automatic randData();
    rng = nextRand(rng); selBits = rng[15:0]; pullCfg = rng[31:16];
    rng = nextRand(rng); gpioOut = rng[15:0]; gpioDir = rng[31:16];
    rng = nextRand(rng); padIn = rng[15:0]; periOut = rng[27:16];
    rng = nextRand(rng); periOe = rng[11:0];
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    {selBits, pullCfg, gpioOut, gpioDir, padIn, locSel, prioRank, serMode, periOut, periOe} = '0;
    #12 rstN = 1'b1;
    #1;
    // Quiet state: everything zero
    check("R1 quiet", {padOut, padOe, padPullEn}, '0);
    check("R9 quiet", 32'(periIn), 0);

    // R4: pull only where select is 0
    selBits = 16'h00FF; pullCfg = 16'hFFFF; #2;
    check("R4", 32'(padPullEn), 32'hFF00);

    // Directed claim cases: ser0 rank1, ser1 rank0, timer rank2, all at location 0
    selBits = 16'hFFFF; locSel = '0; prioRank = 6'b10_00_01;
    periOe = 12'hF0F; periOut = '0;
    serMode = 4'b00_11; #2;  // ser1 UART plain: pins 4,5 go to timer (R8)
    check("R8 uart-plain", 32'(padOe), 32'h00F3);
    serMode = 4'b10_11; #2;  // ser1 SPI master: pin 5 to timer (R8)
    check("R8 spi-master", 32'(padOe), 32'h00E3);
    serMode = 4'b11_11; #2;  // ser1 slave, idle, keeps pins 2..5 (R7)
    check("R7 idle-owner", 32'(padOe), 32'h00C3);

    // R6: equal ranks, lower index wins
    prioRank = '0; periOe = 12'hFF0; #2;
    check("R6 tie", 32'(padOe), 32'h00F0);
    prioRank = 6'b01_00_01; #2;
    check("R6 rank", 32'(padOe), 32'h00FC);

    // R5: ser0 at alternate location drives pins 8..11
    locSel = 3'b001; prioRank = '0; periOut = 12'h00A; periOe = 12'h00F; #2;
    check("R5 alt-loc", 32'(padOut[11:8]), 32'hA);
    check("R5 alt-oe", 32'(padOe[11:8]), 32'hF);

    // Sweep every location, rank and mode combination
    for (int l = 0; l < 8; l++)
      for (int r = 0; r < 64; r++)
        for (int m = 0; m < 16; m++) begin
          locSel = 3'(l); prioRank = 6'(r); serMode = 4'(m);
          randData();
          #2;
          checkAll();
        end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule